// File: doc/BRIEF.md
# Host Port Access Master

This block drives a 16-bit asynchronous host port that exposes four word registers chosen by a 2-bit index. It turns commands from a user-side handshake into timed port cycles. The commands are single-word memory read and write, burst read and write, set-bits, clear-bits, mailbox read and write, and status read. Memory inside the far device is reached indirectly. An address-register write loads the target byte address. Each later data-register access then moves the target on by one 16-bit word.

Every port cycle holds its strobe for a set number of clocks. Strobe starts are always spaced at least six periods of a 48 MHz reference apart. That spacing is converted into local clocks from a clock-frequency parameter. Only one command is accepted at a time. A bit operation's read and write-back therefore can never be split by another access. Burst write data is pulled one word per data cycle. Every word read off the port is returned with a one-cycle valid. Completion is a one-cycle done pulse.

Top module: `hpi_access_master`

## Requirements
- R1: After reset, cmd_ready is 1, done is 0, and port_cs, port_rd and port_wr are all 0.
- R2: Strobe starts on the port are at least GAP_CLKS clocks apart, where GAP_CLKS = ceil(6 * CLK_HZ / 48 MHz), which is 13 at 100 MHz. Each strobe stays high for STROBE_CLKS clocks (3 by default). port_rd and port_wr are never high together.
- R3: Single read (cmd_op 0) writes cmd_addr to index 2 and then reads index 0 once. The word read is returned on rd_data with rd_valid, and then done pulses.
- R4: Single write (cmd_op 1) writes cmd_addr to index 2 and then writes cmd_arg to index 0 once.
- R5: Burst write (cmd_op 2) and burst read (cmd_op 3) make exactly one index-2 write, followed by cmd_len index-0 accesses. Burst write takes wr_word in the cycle wr_take is high, one word per access. Burst read returns each word with rd_valid, in order.
- R6: Set-bits (cmd_op 4) and clear-bits (cmd_op 5) make four accesses in this order: index-2 write, index-0 read, index-2 write, index-0 write. The value written back is old | cmd_arg for set-bits and old & ~cmd_arg for clear-bits. The old value is returned with rd_valid.
- R7: Mailbox read (cmd_op 6) reads index 1. Mailbox write (cmd_op 7) writes cmd_arg to index 1. Status read (cmd_op 8) reads index 3. Each is a single access with no index-2 cycle.
- R8: cmd_ready stays low from command acceptance until after the one-cycle done pulse, so commands never overlap.
- R9: A burst command with cmd_len 0, and any opcode above 8, raises done in the cycle after acceptance and makes no port access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 4 | Command opcode |
| cmd_addr | input | 16 | Target byte address in the far device |
| cmd_arg | input | 16 | Write value or bit mask |
| cmd_len | input | CNT_W | Burst word count |
| wr_take | output | 1 | Burst write word consumed this cycle |
| wr_word | input | 16 | Next burst write word |
| rd_valid | output | 1 | rd_data carries a word read from the port |
| rd_data | output | 16 | Read word |
| done | output | 1 | Command complete pulse |
| port_idx | output | 2 | Port register index |
| port_cs | output | 1 | Port select, high during a strobe |
| port_rd | output | 1 | Read strobe |
| port_wr | output | 1 | Write strobe |
| port_wdata | output | 16 | Port write data |
| port_rdata | input | 16 | Port read data |

## Verification
A model of the far device keeps an address register that steps by two bytes on every data access. Against that model, the bench sweeps burst writes and read-backs of one to six words at several start addresses. These sweeps separate a correct single address phase from a repeated or missing one, and show whether the target advances by one word per access. Set-bits and clear-bits are tried with several mask and old-value pairs so that OR and AND-NOT results differ. The access order is checked to confirm that the address is loaded again before the write-back. Mailbox, status, zero-length bursts and an unused opcode are tried to show that no address phase occurs. Throughout the run, strobe spacing and width are measured on every cycle.

// File: rtl/hpim_pkg.sv
// Shared opcodes, sequencer states and port register indices for the
// host port access master. Assumes a 4-entry register window on the port.
package hpim_pkg;
    typedef enum logic [3:0] {
        OP_RD   = 4'd0,
        OP_WR   = 4'd1,
        OP_BWR  = 4'd2,
        OP_BRD  = 4'd3,
        OP_SET  = 4'd4,
        OP_CLR  = 4'd5,
        OP_MBRD = 4'd6,
        OP_MBWR = 4'd7,
        OP_STAT = 4'd8
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_ADDR, ST_DATA, ST_READDR, ST_WBACK, ST_DIRECT, ST_DONE
    } seq_state_e;

    localparam logic [1:0] IDX_DATA = 2'd0;
    localparam logic [1:0] IDX_MBOX = 2'd1;
    localparam logic [1:0] IDX_ADDR = 2'd2;
    localparam logic [1:0] IDX_STAT = 2'd3;
endpackage

// File: rtl/hpim_cycle_engine.sv
// Port cycle engine: runs one port access per accepted request. Holds the
// strobe for STROBE_CLKS clocks, captures read data on the last strobe clock
// and pulses ack. It stays busy so that the next strobe start is at least
// GAP_CLKS clocks after this one. Assumes req is held until accepted.
module hpim_cycle_engine #(
    parameter int GAP_CLKS    = 13,
    parameter int STROBE_CLKS = 3,
    parameter int DW          = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_rnw,
    input  logic [1:0]    req_idx,
    input  logic [DW-1:0] req_wdata,
    output logic          ready,
    output logic          ack,
    output logic [DW-1:0] ack_rdata,
    output logic [1:0]    port_idx,
    output logic          port_cs,
    output logic          port_rd,
    output logic          port_wr,
    output logic [DW-1:0] port_wdata,
    input  logic [DW-1:0] port_rdata
);
    localparam int CYC_CLKS = (GAP_CLKS - 1 > STROBE_CLKS + 1) ? GAP_CLKS - 1 : STROBE_CLKS + 1;
    localparam int CW       = $clog2(CYC_CLKS + 1);

    logic          busy_q;
    logic [CW-1:0] cnt_q;
    logic          accept;

    assign ready  = !busy_q;
    assign accept = req && !busy_q;

    // Launch, time and retire one port access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q     <= 1'b0;
            cnt_q      <= '0;
            ack        <= 1'b0;
            ack_rdata  <= '0;
            port_idx   <= 2'd0;
            port_cs    <= 1'b0;
            port_rd    <= 1'b0;
            port_wr    <= 1'b0;
            port_wdata <= '0;
        end else begin
            ack <= 1'b0;
            if (accept) begin
                busy_q     <= 1'b1;
                cnt_q      <= '0;
                port_cs    <= 1'b1;
                port_rd    <= req_rnw;
                port_wr    <= !req_rnw;
                port_idx   <= req_idx;
                port_wdata <= req_wdata;
            end else if (busy_q) begin
                cnt_q <= cnt_q + 1'b1;
                if (cnt_q == CW'(STROBE_CLKS - 1)) begin
                    port_cs   <= 1'b0;
                    port_rd   <= 1'b0;
                    port_wr   <= 1'b0;
                    ack       <= 1'b1;
                    ack_rdata <= port_rdata;
                end
                if (cnt_q == CW'(CYC_CLKS - 1)) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    // Checker state: clocks since the last strobe start, saturating at GAP_CLKS.
    localparam int SW = $clog2(GAP_CLKS + 1);
    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_q <= SW'(GAP_CLKS);
        end else if (accept) begin
            since_q <= SW'(1);
        end else if (since_q < SW'(GAP_CLKS)) begin
            since_q <= since_q + 1'b1;
        end
    end

    assert_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> since_q >= SW'(GAP_CLKS));
    assert_no_dual_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(port_rd && port_wr));
    assert_ack_after_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> !port_rd && !port_wr && $past(port_cs));
endmodule

// File: rtl/hpim_sequencer.sv
// Command sequencer: accepts one command at a time and steps it through its
// address phase, data phase and (for bit operations) a re-address and
// write-back phase. It issues each access to the cycle engine and waits for
// its ack. Assumes the engine enforces all cycle timing.
module hpim_sequencer
    import hpim_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [3:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    cmd_arg,
    input  logic [CNT_W-1:0] cmd_len,
    output logic             wr_take,
    input  logic [DW-1:0]    wr_word,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic             eng_req,
    output logic             eng_rnw,
    output logic [1:0]       eng_idx,
    output logic [DW-1:0]    eng_wdata,
    input  logic             eng_ready,
    input  logic             eng_ack,
    input  logic [DW-1:0]    eng_rdata
);
    seq_state_e       state_q;
    op_e              op_q;
    logic [AW-1:0]    addr_q;
    logic [DW-1:0]    arg_q;
    logic [DW-1:0]    old_q;
    logic [CNT_W-1:0] rem_q;
    logic             pend_q;
    logic             issuing;
    logic             is_rmw;
    op_e              new_op;

    assign new_op    = op_e'(cmd_op);
    assign cmd_ready = (state_q == ST_IDLE);
    assign done      = (state_q == ST_DONE);
    assign is_rmw    = (op_q == OP_SET) || (op_q == OP_CLR);
    assign issuing   = (state_q == ST_ADDR) || (state_q == ST_DATA) || (state_q == ST_READDR)
                    || (state_q == ST_WBACK) || (state_q == ST_DIRECT);
    assign eng_req   = issuing && !pend_q && eng_ready;
    assign wr_take   = eng_req && (state_q == ST_DATA) && (op_q == OP_BWR);

    // Select index, direction and write data for the access of the current phase.
    always_comb begin
        eng_rnw   = 1'b0;
        eng_idx   = IDX_DATA;
        eng_wdata = arg_q;
        case (state_q)
            ST_ADDR, ST_READDR: begin
                eng_idx   = IDX_ADDR;
                eng_wdata = DW'(addr_q);
            end
            ST_DATA: begin
                eng_rnw   = (op_q == OP_RD) || (op_q == OP_BRD) || is_rmw;
                eng_wdata = (op_q == OP_BWR) ? wr_word : arg_q;
            end
            ST_WBACK: begin
                eng_wdata = (op_q == OP_SET) ? (old_q | arg_q) : (old_q & ~arg_q);
            end
            ST_DIRECT: begin
                eng_rnw = (op_q != OP_MBWR);
                eng_idx = (op_q == OP_STAT) ? IDX_STAT : IDX_MBOX;
            end
            default: ;
        endcase
    end

    // Advance the command through its phases and collect read words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            op_q     <= OP_RD;
            addr_q   <= '0;
            arg_q    <= '0;
            old_q    <= '0;
            rem_q    <= '0;
            pend_q   <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            if (eng_req) pend_q <= 1'b1;
            if (eng_ack) begin
                pend_q <= 1'b0;
                if (eng_rnw) begin
                    rd_valid <= 1'b1;
                    rd_data  <= eng_rdata;
                end
            end
            case (state_q)
                ST_IDLE: if (cmd_valid) begin
                    op_q   <= new_op;
                    addr_q <= cmd_addr;
                    arg_q  <= cmd_arg;
                    rem_q  <= (new_op == OP_BWR || new_op == OP_BRD) ? cmd_len : CNT_W'(1);
                    if ((new_op == OP_BWR || new_op == OP_BRD) && cmd_len == '0)
                        state_q <= ST_DONE;
                    else if (new_op == OP_MBRD || new_op == OP_MBWR || new_op == OP_STAT)
                        state_q <= ST_DIRECT;
                    else if (cmd_op > 4'd8)
                        state_q <= ST_DONE;
                    else
                        state_q <= ST_ADDR;
                end
                ST_ADDR:   if (eng_ack) state_q <= ST_DATA;
                ST_DATA:   if (eng_ack) begin
                    rem_q <= rem_q - 1'b1;
                    if (is_rmw) old_q <= eng_rdata;
                    if (rem_q == CNT_W'(1)) state_q <= is_rmw ? ST_READDR : ST_DONE;
                end
                ST_READDR: if (eng_ack) state_q <= ST_WBACK;
                ST_WBACK:  if (eng_ack) state_q <= ST_DONE;
                ST_DIRECT: if (eng_ack) state_q <= ST_DONE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    assert_one_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready |=> !cmd_ready);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_zero_burst_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && (cmd_op == 4'd2 || cmd_op == 4'd3) && cmd_len == '0
        |=> done && !eng_req);
    assert_wback_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req && state_q == ST_WBACK |-> !eng_rnw && eng_idx == IDX_DATA);
endmodule

// File: rtl/hpi_access_master.sv
// Host port access master top: converts the reference spacing (REF_GAP
// periods of REF_HZ) into local clocks and connects the command sequencer to
// the port cycle engine. Assumes the port device needs only cycle spacing,
// not finer pin timing.
module hpi_access_master #(
    parameter int CLK_HZ      = 100_000_000,
    parameter int REF_HZ      = 48_000_000,
    parameter int REF_GAP     = 6,
    parameter int STROBE_CLKS = 3,
    parameter int AW          = 16,
    parameter int DW          = 16,
    parameter int CNT_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [3:0]       cmd_op,
    input  logic [AW-1:0]    cmd_addr,
    input  logic [DW-1:0]    cmd_arg,
    input  logic [CNT_W-1:0] cmd_len,
    output logic             wr_take,
    input  logic [DW-1:0]    wr_word,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             done,
    output logic [1:0]       port_idx,
    output logic             port_cs,
    output logic             port_rd,
    output logic             port_wr,
    output logic [DW-1:0]    port_wdata,
    input  logic [DW-1:0]    port_rdata
);
    localparam int GAP_CLKS = int'((longint'(REF_GAP) * longint'(CLK_HZ) + longint'(REF_HZ) - 1)
                                   / longint'(REF_HZ));

    logic          eng_req, eng_rnw, eng_ready, eng_ack;
    logic [1:0]    eng_idx;
    logic [DW-1:0] eng_wdata, eng_rdata;

    hpim_sequencer #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_arg(cmd_arg), .cmd_len(cmd_len),
        .wr_take(wr_take), .wr_word(wr_word),
        .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
        .eng_req(eng_req), .eng_rnw(eng_rnw), .eng_idx(eng_idx), .eng_wdata(eng_wdata),
        .eng_ready(eng_ready), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    hpim_cycle_engine #(.GAP_CLKS(GAP_CLKS), .STROBE_CLKS(STROBE_CLKS), .DW(DW)) eng_i (
        .clk(clk), .rst_n(rst_n),
        .req(eng_req), .req_rnw(eng_rnw), .req_idx(eng_idx), .req_wdata(eng_wdata),
        .ready(eng_ready), .ack(eng_ack), .ack_rdata(eng_rdata),
        .port_idx(port_idx), .port_cs(port_cs), .port_rd(port_rd), .port_wr(port_wr),
        .port_wdata(port_wdata), .port_rdata(port_rdata)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> cmd_ready && !done && !port_cs);
endmodule

// File: tb/hpi_access_master_tb.sv
module hpi_access_master_tb_top;
    localparam int GAP    = (6 * 100_000_000 + 48_000_000 - 1) / 48_000_000;
    localparam int STROBE = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready, wr_take, rd_valid, done, port_cs, port_rd, port_wr;
    logic [3:0]  cmd_op = '0;
    logic [15:0] cmd_addr = '0, cmd_arg = '0, wr_word, rd_data, port_wdata, port_rdata;
    logic [7:0]  cmd_len = '0;
    logic [1:0]  port_idx;

    always #5 clk = ~clk;

    hpi_access_master dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_arg(cmd_arg), .cmd_len(cmd_len),
        .wr_take(wr_take), .wr_word(wr_word), .rd_valid(rd_valid), .rd_data(rd_data),
        .done(done), .port_idx(port_idx), .port_cs(port_cs), .port_rd(port_rd),
        .port_wr(port_wr), .port_wdata(port_wdata), .port_rdata(port_rdata)
    );

    int tests = 0, fails = 0;
    // far device model
    logic [15:0] mem [256];
    logic [15:0] areg = '0, mbox_in = '0, mbox_out = 16'h5A3C, stat_reg = 16'h00C1;
    assign port_rdata = (port_idx == 2'd0) ? mem[areg[8:1]] :
                        (port_idx == 2'd1) ? mbox_out :
                        (port_idx == 2'd3) ? stat_reg : areg;
    // burst write source
    logic [15:0] bw_src [8];
    int bw_ptr = 0;
    assign wr_word = bw_src[bw_ptr[2:0]];
    always @(posedge clk) if (wr_take) bw_ptr <= bw_ptr + 1;

    // traces
    int n_cyc = 0, n_addr = 0, since = 1000, width = 0, sp_bad = 0, wd_bad = 0, both_bad = 0;
    logic [1:0] seq_idx [8];
    logic       seq_rd  [8];
    logic [15:0] rd_buf [8];
    int rd_n = 0;
    logic prev_rd = 1'b0, prev_wr = 1'b0;

    always @(negedge clk) begin
        since = since + 1;
        if (port_rd && port_wr) both_bad++;
        if ((port_rd || port_wr) && !(prev_rd || prev_wr)) begin
            if (since < GAP) sp_bad++;
            since = 0;
            width = 0;
            if (n_cyc < 8) begin seq_idx[n_cyc] = port_idx; seq_rd[n_cyc] = port_rd; end
            n_cyc++;
            if (port_idx == 2'd2) n_addr++;
            if (port_wr) begin
                case (port_idx)
                    2'd2: areg = port_wdata;
                    2'd0: begin mem[areg[8:1]] = port_wdata; areg = areg + 16'd2; end
                    2'd1: mbox_in = port_wdata;
                    default: ;
                endcase
            end
        end
        if (port_rd || port_wr) width++;
        if (!(port_rd || port_wr) && (prev_rd || prev_wr) && width != STROBE) wd_bad++;
        if (!port_rd && prev_rd && port_idx == 2'd0) areg = areg + 16'd2;
        if (rd_valid && rd_n < 8) begin rd_buf[rd_n] = rd_data; rd_n++; end
        prev_rd = port_rd;
        prev_wr = port_wr;
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    int lat, busy_ready;
    task automatic run(input logic [3:0] op, input logic [15:0] a, input logic [15:0] g,
                       input logic [7:0] n);
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_arg = g; cmd_len = n; cmd_valid = 1'b1;
        n_cyc = 0; n_addr = 0; rd_n = 0; bw_ptr = 0; lat = 0; busy_ready = 0;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 3000) begin
            if (cmd_ready) busy_ready++;
            @(negedge clk);
            lat++;
        end
        if (lat >= 3000) chk(1'b0, "watchdog run", lat, 0);
        if (cmd_ready) busy_ready++;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        tests++; fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'(i * 16'h0101 ^ 16'h1234);
        repeat (3) @(negedge clk);
        chk(cmd_ready && !done && !port_cs && !port_rd && !port_wr, "R1 reset state",
            {cmd_ready, done, port_cs, port_rd, port_wr}, 5'b10000);
        @(negedge clk) rst_n = 1'b1;

        // R4 / R3 single write and read sweep
        for (int k = 0; k < 4; k++) begin
            logic [15:0] ad, v;
            ad = 16'(16'h0020 + k * 6);
            v  = 16'(16'hA000 + k * 16'h0111);
            run(4'd1, ad, v, 8'd0);
            chk(mem[ad[8:1]] == v && n_cyc == 2 && seq_idx[0] == 2'd2 && seq_idx[1] == 2'd0
                && !seq_rd[1], "R4 single write", mem[ad[8:1]], v);
            run(4'd0, ad, 16'h0, 8'd0);
            chk(rd_n == 1 && rd_buf[0] == v && n_cyc == 2 && n_addr == 1 && seq_rd[1],
                "R3 single read", rd_buf[0], v);
            chk(busy_ready == 0, "R8 ready low while busy", busy_ready, 0);
        end

        // R5 burst write / read sweep over lengths
        for (int n = 1; n <= 6; n++) begin
            logic [15:0] base;
            base = 16'(16'h0080 + n * 16);
            for (int j = 0; j < 8; j++) bw_src[j] = 16'(n * 16'h1000 + j * 16'h0011 + 16'h0007);
            run(4'd2, base, 16'h0, 8'(n));
            chk(n_cyc == n + 1 && n_addr == 1, "R5 burst write cycles", n_cyc, n + 1);
            for (int j = 0; j < n; j++)
                chk(mem[base[8:1] + 8'(j)] == bw_src[j], "R5 burst write data",
                    mem[base[8:1] + 8'(j)], bw_src[j]);
            chk(mem[base[8:1] + 8'(n)] != bw_src[n], "R5 burst write stops", n, n);
            run(4'd3, base, 16'h0, 8'(n));
            chk(rd_n == n && n_cyc == n + 1 && n_addr == 1, "R5 burst read count", rd_n, n);
            for (int j = 0; j < n; j++)
                chk(rd_buf[j] == bw_src[j], "R5 burst read data", rd_buf[j], bw_src[j]);
        end

        // R6 set / clear bits
        for (int k = 0; k < 4; k++) begin
            logic [15:0] ad, old, m;
            ad  = 16'(16'h0100 + k * 2);
            m   = 16'(16'h0F0F << k);
            old = 16'(16'h3355 ^ (k * 16'h1111));
            mem[ad[8:1]] = old;
            run(4'd4, ad, m, 8'd0);
            chk(mem[ad[8:1]] == (old | m), "R6 set bits", mem[ad[8:1]], old | m);
            chk(n_cyc == 4 && seq_idx[0] == 2'd2 && seq_idx[1] == 2'd0 && seq_rd[1]
                && seq_idx[2] == 2'd2 && seq_idx[3] == 2'd0 && !seq_rd[3],
                "R6 set order", n_cyc, 4);
            chk(rd_n == 1 && rd_buf[0] == old, "R6 set old value", rd_buf[0], old);
            old = mem[ad[8:1]];
            run(4'd5, ad, m, 8'd0);
            chk(mem[ad[8:1]] == (old & ~m), "R6 clear bits", mem[ad[8:1]], old & ~m);
            chk(n_cyc == 4 && n_addr == 2, "R6 clear order", n_cyc, 4);
        end

        // R7 mailbox and status
        run(4'd7, 16'h0040, 16'hBEEF, 8'd0);
        chk(mbox_in == 16'hBEEF && n_cyc == 1 && n_addr == 0 && seq_idx[0] == 2'd1,
            "R7 mailbox write", mbox_in, 16'hBEEF);
        run(4'd6, 16'h0040, 16'h0, 8'd0);
        chk(rd_n == 1 && rd_buf[0] == mbox_out && n_cyc == 1 && n_addr == 0,
            "R7 mailbox read", rd_buf[0], mbox_out);
        run(4'd8, 16'h0040, 16'h0, 8'd0);
        chk(rd_n == 1 && rd_buf[0] == stat_reg && n_cyc == 1 && seq_idx[0] == 2'd3,
            "R7 status read", rd_buf[0], stat_reg);

        // R9 zero-length bursts and unused opcode
        run(4'd2, 16'h0010, 16'h0, 8'd0);
        chk(lat == 1 && n_cyc == 0, "R9 zero burst write", lat, 1);
        run(4'd3, 16'h0010, 16'h0, 8'd0);
        chk(lat == 1 && n_cyc == 0 && rd_n == 0, "R9 zero burst read", lat, 1);
        run(4'd12, 16'h0010, 16'h0, 8'd0);
        chk(lat == 1 && n_cyc == 0, "R9 unused opcode", lat, 1);

        // R2 timing summary
        chk(sp_bad == 0, "R2 strobe spacing", sp_bad, 0);
        chk(wd_bad == 0, "R2 strobe width", wd_bad, 0);
        chk(both_bad == 0, "R2 single strobe", both_bad, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule